// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs one clause-22 management transaction towards an external PHY. Software writes a single 32-bit command word whose layout is the management frame itself: start code, operation code, PHY address, register number, turnaround code and 16 data bits. The engine first sends a 32-bit preamble of ones and then shifts that word out on MDIO, MSB first, one bit per MDC period. MDC is derived from the system clock by a selectable divider.

For a read, the engine releases MDIO after the start, opcode, PHY address and register fields. It then samples the PHY's 16 data bits on rising MDC edges. When the frame ends, those bits replace the low half of the command register, so software reads the result back from the same place it wrote the command.

Software polls the idle flag to learn that a transaction is complete. A port enable gates the whole engine. While the port is disabled, MDC is silent and commands are dropped.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is 0.
- R2: A `cmd_wr` pulse while `idle` is 1 and `mgmt_en` is 1 loads `cmd_wdata` into the command register, visible on `cmd_rdata` the next cycle, and `idle` drops to 0 in that same cycle.
- R3: While a frame runs, MDC has period 4*(S+1) clock cycles. It is low for the first half and high for the second. S is the value of `mdc_div_sel` at the accepting edge.
- R4: The frame is 64 MDC periods long. Periods 0 to 31 drive 1. Period 32+i drives command bit 31-i. MDIO changes only while MDC is low.
- R5: The command is a read when bits 29:28 equal 2'b10; any other value is a write. During a read, `mdio_oe` is 0 for the last 18 periods (turnaround and data). During a write, `mdio_oe` stays 1 for the whole frame.
- R6: During a read, `mdio_i` is sampled at each rising MDC edge of the last 16 periods, first bit as MSB. At completion these bits replace `cmd_rdata[15:0]`, and bits 31:16 are unchanged.
- R7: After a write frame, `cmd_rdata` still holds the written command word.
- R8: `idle` stays 0 for 128*H clock cycles after acceptance and then returns to 1, where H = 2*(S+1). While idle, MDC is 0 and `mdio_oe` is 0.
- R9: A `cmd_wr` while `idle` is 0 is ignored. The frame continues unchanged and `cmd_rdata[31:16]` keeps its value.
- R10: While `mgmt_en` is 0, commands are ignored, `idle` is 1 and MDC stays 0. A frame in progress is abandoned on the cycle after the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_en | input | 1 | Management port enable |
| mdc_div_sel | input | SEL_W | MDC divider select S; period is 2*HALF_BASE*(S+1) clocks |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word (frame image) |
| cmd_rdata | output | 32 | Command register read-back, low half holds read data |
| idle | output | 1 | 1 when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench uses the default parameters, SEL_W = 3 and HALF_BASE = 2, so half-periods range from 2 to 16 clocks. It runs frames with divider selects 0, 1, 2, 3 and 7. This covers the shortest MDC half-period, where the rising-edge sample lands only two cycles after the drive change, and the longest, where a frame lasts 2048 cycles. Read data patterns with only the MSB and LSB set check the capture order. A mid-frame disable and a command issued during a busy frame check that frames are abandoned cleanly and that late commands are ignored.

// File: rtl/mdio_eng_pkg.sv
// Shared constants for the MDIO frame engine.
// Assumes the clause-22 frame layout where the command word equals the frame.
package mdio_eng_pkg;
    localparam int WORD_W       = 32;  // command word / frame body width
    localparam int DATA_W       = 16;  // data field width
    localparam int PREAMBLE_LEN = 32;  // preamble ones before the frame body
    localparam int HDR_BITS     = 14;  // start + opcode + PHY addr + reg addr
    localparam int OP_HI        = 29;  // opcode field upper bit
    localparam int OP_LO        = 28;  // opcode field lower bit

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;

    // Decide whether a command word requests a read.
    function automatic logic word_is_read(input logic [WORD_W-1:0] w);
        return w[OP_HI:OP_LO] == OPC_READ;
    endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
// MDC generator: divides clk into MDC periods of 2*half clocks, low half first.
// Assumes start and run are never high together; half is latched at start.
module mdio_clk_gen #(
    parameter int SEL_W     = 3,
    parameter int HALF_BASE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    localparam int HALF_MAX = HALF_BASE * (2 ** SEL_W);
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] cnt_q;
    logic             phase_hi_q;
    logic             half_end;

    // Detect the last clock of the current MDC half-period.
    always_comb begin
        half_end = (cnt_q == half_q - CNT_W'(1));
        rise_evt = run && !phase_hi_q && half_end;
        fall_evt = run &&  phase_hi_q && half_end;
    end

    // Count half-periods and toggle MDC at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q     <= CNT_W'(HALF_BASE);
            cnt_q      <= '0;
            phase_hi_q <= 1'b0;
            mdc        <= 1'b0;
        end else if (start) begin
            half_q     <= CNT_W'(HALF_BASE * (int'(div_sel) + 1));
            cnt_q      <= '0;
            phase_hi_q <= 1'b0;
            mdc        <= 1'b0;
        end else if (run) begin
            if (half_end) begin
                cnt_q      <= '0;
                phase_hi_q <= !phase_hi_q;
                mdc        <= !phase_hi_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else begin
            cnt_q      <= '0;
            phase_hi_q <= 1'b0;
            mdc        <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_frame_shifter.sv
// Frame shifter: sends preamble then the command word MSB first, releases
// MDIO for read turnaround/data, and captures read data on MDC rise events.
// Assumes rise_evt/fall_evt come from mdio_clk_gen and are low when idle.
module mdio_frame_shifter
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              is_read,
    output logic [DATA_W-1:0] cap_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int TOTAL        = PREAMBLE_LEN + WORD_W;
    localparam int BIT_W        = $clog2(TOTAL);
    localparam int LAST         = TOTAL - 1;
    localparam int RELEASE_FROM = PREAMBLE_LEN + HDR_BITS;
    localparam int CAP_FROM     = TOTAL - DATA_W;

    logic [BIT_W-1:0]  bit_q;
    logic [BIT_W-1:0]  nxt;
    logic [BIT_W-1:0]  frame_pos;
    logic [WORD_W-1:0] frame_q;
    logic [WORD_W-1:0] shifted;
    logic              nxt_val;
    logic              nxt_oe;
    logic              at_last;

    // Work out the value and drive enable of the next bit period.
    always_comb begin
        nxt       = bit_q + BIT_W'(1);
        frame_pos = nxt - BIT_W'(PREAMBLE_LEN);
        shifted   = frame_q << frame_pos;
        nxt_val   = (nxt < BIT_W'(PREAMBLE_LEN)) ? 1'b1 : shifted[WORD_W-1];
        nxt_oe    = !(is_read && (nxt >= BIT_W'(RELEASE_FROM)));
        at_last   = (bit_q == BIT_W'(LAST));
        done      = busy && fall_evt && at_last;
    end

    // Sequence bit periods, drive MDIO and shift in read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            bit_q    <= '0;
            frame_q  <= '0;
            is_read  <= 1'b0;
            cap_data <= '0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
        end else if (abort) begin
            busy    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            bit_q    <= '0;
            frame_q  <= cmd_word;
            is_read  <= word_is_read(cmd_word);
            cap_data <= '0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b1;
        end else if (busy) begin
            if (rise_evt && is_read && (bit_q >= BIT_W'(CAP_FROM)))
                cap_data <= {cap_data[DATA_W-2:0], mdio_i};
            if (fall_evt) begin
                if (at_last) begin
                    busy    <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    bit_q   <= nxt;
                    mdio_o  <= nxt_val;
                    mdio_oe <= nxt_oe;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_reg.sv
// Command register: holds the last accepted command word and takes read data
// into its low half when a read frame completes.
// Assumes accept and done never occur in the same cycle.
module mdio_cmd_reg
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done,
    input  logic              done_is_read,
    input  logic [DATA_W-1:0] cap_data,
    output logic [WORD_W-1:0] reg_q
);
    // Load on accept; merge captured data on read completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (accept)
            reg_q <= wdata;
        else if (done && done_is_read)
            reg_q[DATA_W-1:0] <= cap_data;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Top of the MDIO management frame engine: accepts one command word, runs a
// clause-22 frame on MDC/MDIO and reports completion through idle.
// Assumes mdio_i is synchronous to clk (or externally synchronised).
module mdio_frame_engine
    import mdio_eng_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int HALF_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_en,
    input  logic [SEL_W-1:0]  mdc_div_sel,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic [WORD_W-1:0] cmd_rdata,
    output logic              idle,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              busy;
    logic              accept;
    logic              run;
    logic              rise_evt;
    logic              fall_evt;
    logic              done;
    logic              is_read;
    logic [DATA_W-1:0] cap_data;

    // Accept a command only when enabled and idle; run only while enabled.
    always_comb begin
        accept = cmd_wr && mgmt_en && !busy;
        run    = busy && mgmt_en;
        idle   = !busy;
    end

    mdio_clk_gen #(
        .SEL_W     (SEL_W),
        .HALF_BASE (HALF_BASE)
    ) u_clk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .run      (run),
        .div_sel  (mdc_div_sel),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_shifter u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .abort    (!mgmt_en),
        .cmd_word (cmd_wdata),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .is_read  (is_read),
        .cap_data (cap_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mdio_cmd_reg u_cmd_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .wdata        (cmd_wdata),
        .done         (done),
        .done_is_read (is_read),
        .cap_data     (cap_data),
        .reg_q        (cmd_rdata)
    );
endmodule

// File: rtl/mdio_frame_engine_chk.sv
// Protocol checker for mdio_frame_engine, attached with bind.
// Assumes rst_n is low from time zero until the first clock edges.
module mdio_frame_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mgmt_en,
    input logic        cmd_wr,
    input logic [31:0] cmd_wdata,
    input logic [31:0] cmd_rdata,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R2: an accepted command makes the engine busy and loads the register.
    assert_accept_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_wr && mgmt_en) |=> (!idle && cmd_rdata == $past(cmd_wdata)));

    // R4: a driven MDIO value only changes while MDC is low.
    assert_mdio_moves_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc);

    // R8: the bus is quiet whenever the engine is idle.
    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));

    // R9: while busy, no new command reaches the upper register half.
    assert_busy_keeps_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(cmd_rdata[31:16]));

    // R10: a disabled port is idle with MDC low on the next cycle.
    assert_disable_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> (idle && !mdc));
endmodule

bind mdio_frame_engine mdio_frame_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mgmt_en   (mgmt_en),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .idle      (idle),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_frame_engine_tb.sv
`timescale 1ns/1ps
// Bench for mdio_frame_engine: a behavioural per-cycle model plus a PHY responder.
module mdio_frame_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_en = 1'b0;
    logic [2:0]  mdc_div_sel = '0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit cmp_on = 0;

    // Reference model state
    int          m_busy = 0, m_t = 0, m_h = 2;
    logic [31:0] m_cmd = '0, m_reg = '0;
    logic [15:0] m_cap = '0;
    logic [15:0] phy_data = '0;
    bit          m_rd = 0;

    always #10 clk = ~clk;

    mdio_frame_engine u_dut (
        .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .mdc_div_sel(mdc_div_sel),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    // Behavioural model, advanced on each rising clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_reg = '0;
        end else if (!mgmt_en) begin
            m_busy = 0;
        end else if (m_busy != 0) begin
            m_t++;
            if (m_rd && (m_t % (2*m_h)) == m_h && (m_t / (2*m_h)) >= 48)
                m_cap = {m_cap[14:0], mdio_i};
            if (m_t == 128*m_h) begin
                m_busy = 0;
                if (m_rd) m_reg[15:0] = m_cap;
            end
        end else if (cmd_wr) begin
            m_busy = 1; m_t = 0; m_cmd = cmd_wdata; m_reg = cmd_wdata;
            m_h = 2 * (int'(mdc_div_sel) + 1);
            m_rd = (cmd_wdata[29:28] == 2'b10);
            m_cap = '0;
        end
    end

    // PHY responder and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int k;
        bit e_mdc, e_oe, e_o;
        k = m_t / (2*m_h);
        mdio_i <= (m_busy != 0 && m_rd && k >= 48) ? phy_data[63-k] : 1'b1;
        if (cmp_on) begin
            e_mdc = (m_busy != 0) && ((m_t % (2*m_h)) >= m_h);
            e_oe  = (m_busy != 0) && !(m_rd && k >= 46);
            e_o   = (k < 32) ? 1'b1 : m_cmd[63-k];
            check("R8 idle", {31'b0, idle}, {31'b0, m_busy == 0});
            check("R3 mdc", {31'b0, mdc}, {31'b0, e_mdc});
            check("R5 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) check("R4 mdio_o", {31'b0, mdio_o}, {31'b0, e_o});
            check("R6/R7 cmd_rdata", cmd_rdata, m_reg);
        end
    end

    task automatic issue(input logic [31:0] w, input logic [2:0] sel);
        @(negedge clk);
        cmd_wdata = w; mdc_div_sel = sel; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!idle);
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    initial begin
        logic [31:0] w;
        int per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 idle", {31'b0, idle}, 32'd1);
        check("R1 mdc", {31'b0, mdc}, 32'd0);
        check("R1 mdio_oe", {31'b0, mdio_oe}, 32'd0);
        check("R1 cmd_rdata", cmd_rdata, 32'd0);
        cmp_on = 1;
        mgmt_en = 1'b1;

        // R2/R7 write frame at fastest divider
        w = mk(2'b01, 5'h05, 5'h0A, 16'hA5C3);
        issue(w, 3'd0);
        check("R2 idle low after accept", {31'b0, idle}, 32'd0);
        check("R2 register loaded", cmd_rdata, w);
        wait_idle();
        check("R7 write word kept", cmd_rdata, w);

        // R6 read frame, plus R9 command during busy
        phy_data = 16'h3C96;
        w = mk(2'b10, 5'h1F, 5'h01, 16'hFFFF);
        issue(w, 3'd1);
        repeat (40) @(negedge clk);
        issue(mk(2'b01, 5'h00, 5'h00, 16'h0000), 3'd0);
        check("R9 busy command ignored", cmd_rdata, w);
        wait_idle();
        check("R6 read data merged", cmd_rdata, {w[31:16], 16'h3C96});

        // R6 capture order with edge bits only
        phy_data = 16'h8001;
        w = mk(2'b10, 5'h00, 5'h1F, 16'h0000);
        issue(w, 3'd3);
        wait_idle();
        check("R6 msb-first order", cmd_rdata, {w[31:16], 16'h8001});

        // R3 explicit period measurement with select 2
        w = mk(2'b01, 5'h11, 5'h04, 16'h1234);
        issue(w, 3'd2);
        while (!mdc) @(negedge clk);
        per = 0;
        while (mdc) begin @(negedge clk); per++; end
        while (!mdc) begin @(negedge clk); per++; end
        check("R3 period for select 2", per, 32'd12);
        wait_idle();

        // R10 disable mid frame
        issue(mk(2'b01, 5'h02, 5'h03, 16'hBEEF), 3'd1);
        repeat (100) @(negedge clk);
        mgmt_en = 1'b0;
        @(negedge clk);
        check("R10 abandoned idle", {31'b0, idle}, 32'd1);
        check("R10 mdc low", {31'b0, mdc}, 32'd0);
        w = cmd_rdata;
        issue(mk(2'b01, 5'h07, 5'h07, 16'h7777), 3'd0);
        repeat (5) @(negedge clk);
        check("R10 command ignored", cmd_rdata, w);
        check("R10 stays idle", {31'b0, idle}, 32'd1);
        mgmt_en = 1'b1;

        // R3/R4 slowest divider write
        w = mk(2'b01, 5'h15, 5'h0E, 16'h5AF0);
        issue(w, 3'd7);
        wait_idle();
        check("R7 slow write word kept", cmd_rdata, w);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule